// File: doc/BRIEF.md
# Enhanced Parallel Port Cycle Gating Controller

This block owns the enhanced-mode address and data registers of a parallel port controller. A host writes and reads a small register window. Accesses to the address-cycle and data-cycle registers become byte transactions on a peripheral-side request/acknowledge interface. Before it starts any such cycle, the block checks the stored control byte. A direction, strobe, auto-feed, init and select pattern that does not match the one required for that transfer direction makes the block drop the access without a word.

Data accesses may be one, two or four bytes wide. The block splits them into single-byte peripheral cycles, lowest byte first, and stays busy until the last byte is acknowledged. A peripheral error ends the access at once and sets a sticky timeout flag. Software clears that flag through the status register. A control write that flips the direction bit raises a one-cycle notification. The control lines driven toward the port are the stored control byte with the direction bit forced low.

Top module: `epp_cycle_ctrl`

## Requirements
- R1: Register offsets are 1 = status, 2 = control, 3 = address cycle, 4 = data cycle. Every host access to an idle block ends with a one-cycle `host_done` one cycle after the request is taken. Control reads return the stored byte, and status reads return the timeout flag in bit 0 with zeros above it. Any other offset reads zero. After reset, control holds 0x0C and the timeout flag is 0.
- R2: A write cycle on offset 3 or 4 starts only when (control AND 0x2F) equals 0x04.
- R3: A read cycle on offset 3 or 4 starts only when (control AND 0x2F) equals 0x24. Control bits 4, 6 and 7 have no influence on either decision.
- R4: A cycle that the control pattern forbids issues no peripheral request and still completes. A forbidden write returns 0. A forbidden read returns all ones at its width: 0xFF, 0x0000FFFF or 0xFFFFFFFF.
- R5: On offset 4, `host_size` 0 selects one byte, 1 selects two bytes, and 2 or 3 selects four bytes. Offset 3 always moves exactly one byte, whatever the size. Bytes are moved least significant first, and read bytes are assembled at their own lane. `per_is_addr` is 1 for offset 3.
- R6: Each byte gets exactly one request. `per_req` stays high with stable data and direction until `per_ack`, then drops for at least one cycle before the next byte.
- R7: A peripheral error on any byte sets the timeout flag and ends the access without further requests. A read then returns the bytes received before the error, with all other lanes inside its width set to ones.
- R8: The timeout flag is sticky through later successful cycles. A status write with bit 0 set clears it, and a status write with bit 0 clear leaves it unchanged.
- R9: `ctl_lines` equals the stored control byte with bit 5 forced to 0, and `dir_read` equals bit 5. `dir_chg` is high for exactly one cycle after a control write that changes bit 5, and stays low otherwise.
- R10: While `host_busy` is high, `host_req` is ignored and `host_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host access request, taken when not busy |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Register offset |
| host_size | input | 2 | Data access width code |
| host_wdata | input | 32 | Write data |
| host_busy | output | 1 | Multi-byte peripheral access in progress |
| host_done | output | 1 | One-cycle access completion |
| host_rdata | output | 32 | Read result, valid with host_done |
| per_req | output | 1 | Peripheral byte cycle request |
| per_we | output | 1 | Peripheral cycle direction, 1 = write |
| per_is_addr | output | 1 | 1 = address cycle, 0 = data cycle |
| per_wdata | output | 8 | Byte sent on a write cycle |
| per_ack | input | 1 | Peripheral completion of the current byte |
| per_err | input | 1 | Peripheral failure, valid with per_ack |
| per_rdata | input | 8 | Byte returned on a read cycle, valid with per_ack |
| ctl_lines | output | 8 | Control byte toward the port, direction bit cleared |
| dir_read | output | 1 | Stored direction bit |
| dir_chg | output | 1 | One-cycle pulse on a direction change |

## Verification
The gate is tried with the exact write pattern (0x04) and the exact read pattern (0x24). It is also tried with each of these patterns paired with the wrong transfer direction, with one masked bit flipped (select, strobe), and with the unmasked bits 4 and 7 set. This separates a correct mask-and-compare from a test on the direction bit alone or one with the wrong mask. Byte, halfword, word and size-code-3 accesses are run in both directions. The bench logs each peripheral byte, so both the lane order and the count of requests are checked, and the count of `per_req` rising edges shows whether the line is re-armed for every byte. Injecting an error on the first and on a middle byte tells early abort and partial read assembly apart from a plain flag set.

// File: rtl/epp_cycle_pkg.sv
package epp_cycle_pkg;
    localparam logic [2:0] OFS_STAT   = 3'd1;
    localparam logic [2:0] OFS_CTRL   = 3'd2;
    localparam logic [2:0] OFS_EADDR  = 3'd3;
    localparam logic [2:0] OFS_EDATA  = 3'd4;
    localparam logic [7:0] CTRL_RESET = 8'h0C;
    localparam int         DIR_BIT    = 5;
    localparam logic [7:0] GATE_MASK  = 8'h2F;
    localparam logic [7:0] GATE_WR    = 8'h04;
    localparam logic [7:0] GATE_RD    = 8'h24;
endpackage

// File: rtl/epp_cycle_gate.sv
module epp_cycle_gate
    import epp_cycle_pkg::*;
(
    input  logic [7:0] ctrl,
    output logic       wr_ok,
    output logic       rd_ok
);
    logic [7:0] masked;
    assign masked = ctrl & GATE_MASK;
    assign wr_ok  = (masked == GATE_WR);
    assign rd_ok  = (masked == GATE_RD);
endmodule

// File: rtl/epp_width_decode.sv
module epp_width_decode #(
    parameter int DATA_BYTES = 4,
    localparam int IDX_W = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1,
    localparam int DW = 8 * DATA_BYTES
) (
    input  logic [1:0]       size,
    input  logic             is_addr,
    output logic [IDX_W-1:0] last,
    output logic [DW-1:0]    mask
);
    int n;
    always_comb begin
        if (is_addr) begin
            n = 1;
        end else begin
            case (size)
                2'd0:    n = 1;
                2'd1:    n = 2;
                default: n = 4;
            endcase
        end
        if (n > DATA_BYTES) n = DATA_BYTES;
        last = IDX_W'(n - 1);
    end

    for (genvar i = 0; i < DATA_BYTES; i++) begin : g_lane
        assign mask[8*i +: 8] = (IDX_W'(i) <= last) ? 8'hFF : 8'h00;
    end
endmodule

// File: rtl/epp_byte_lanes.sv
module epp_byte_lanes #(
    parameter int DATA_BYTES = 4,
    localparam int IDX_W = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1,
    localparam int DW = 8 * DATA_BYTES
) (
    input  logic [DW-1:0]    wbuf,
    input  logic [DW-1:0]    rbuf,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       in_byte,
    output logic [7:0]       out_byte,
    output logic [DW-1:0]    merged
);
    assign out_byte = wbuf[{idx, 3'b000} +: 8];

    for (genvar i = 0; i < DATA_BYTES; i++) begin : g_merge
        assign merged[8*i +: 8] = (IDX_W'(i) == idx) ? in_byte : rbuf[8*i +: 8];
    end
endmodule

// File: rtl/epp_cycle_ctrl.sv
module epp_cycle_ctrl
    import epp_cycle_pkg::*;
#(
    parameter int DATA_BYTES = 4,
    localparam int IDX_W = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1,
    localparam int DW = 8 * DATA_BYTES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_req,
    input  logic          host_we,
    input  logic [2:0]    host_addr,
    input  logic [1:0]    host_size,
    input  logic [DW-1:0] host_wdata,
    output logic          host_busy,
    output logic          host_done,
    output logic [DW-1:0] host_rdata,
    output logic          per_req,
    output logic          per_we,
    output logic          per_is_addr,
    output logic [7:0]    per_wdata,
    input  logic          per_ack,
    input  logic          per_err,
    input  logic [7:0]    per_rdata,
    output logic [7:0]    ctl_lines,
    output logic          dir_read,
    output logic          dir_chg
);
    typedef struct packed {
        logic             busy;
        logic             preq;
        logic             pwe;
        logic             pisaddr;
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] last;
        logic [DW-1:0]    wbuf;
        logic [DW-1:0]    rbuf;
        logic             done;
        logic [DW-1:0]    rdata;
        logic [7:0]       ctrl;
        logic             tmo;
        logic             dirchg;
    } state_t;

    state_t q, d;

    logic             wr_ok, rd_ok;
    logic [IDX_W-1:0] last_w;
    logic [DW-1:0]    mask_w;
    logic [DW-1:0]    merged;
    logic             tmo_flag;

    epp_cycle_gate u_gate (
        .ctrl  (q.ctrl),
        .wr_ok (wr_ok),
        .rd_ok (rd_ok)
    );

    epp_width_decode #(.DATA_BYTES(DATA_BYTES)) u_width (
        .size    (host_size),
        .is_addr (host_addr == OFS_EADDR),
        .last    (last_w),
        .mask    (mask_w)
    );

    epp_byte_lanes #(.DATA_BYTES(DATA_BYTES)) u_lanes (
        .wbuf     (q.wbuf),
        .rbuf     (q.rbuf),
        .idx      (q.idx),
        .in_byte  (per_rdata),
        .out_byte (per_wdata),
        .merged   (merged)
    );

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        d.dirchg = 1'b0;
        if (!q.busy) begin
            if (host_req) begin
                d.done  = 1'b1;
                d.rdata = '0;
                case (host_addr)
                    OFS_STAT: begin
                        if (host_we) begin
                            if (host_wdata[0]) d.tmo = 1'b0;
                        end else begin
                            d.rdata = DW'(q.tmo);
                        end
                    end
                    OFS_CTRL: begin
                        if (host_we) begin
                            d.ctrl   = host_wdata[7:0];
                            d.dirchg = host_wdata[DIR_BIT] ^ q.ctrl[DIR_BIT];
                        end else begin
                            d.rdata = DW'(q.ctrl);
                        end
                    end
                    OFS_EADDR, OFS_EDATA: begin
                        if (host_we ? wr_ok : rd_ok) begin
                            d.done    = 1'b0;
                            d.busy    = 1'b1;
                            d.preq    = 1'b1;
                            d.pwe     = host_we;
                            d.pisaddr = (host_addr == OFS_EADDR);
                            d.idx     = '0;
                            d.last    = last_w;
                            d.wbuf    = host_wdata;
                            d.rbuf    = mask_w;
                        end else if (!host_we) begin
                            d.rdata = mask_w;
                        end
                    end
                    default: ;
                endcase
            end
        end else if (q.preq) begin
            if (per_ack) begin
                d.preq = 1'b0;
                if (per_err) begin
                    d.tmo   = 1'b1;
                    d.busy  = 1'b0;
                    d.done  = 1'b1;
                    d.rdata = q.pwe ? '0 : q.rbuf;
                end else begin
                    if (!q.pwe) d.rbuf = merged;
                    if (q.idx == q.last) begin
                        d.busy  = 1'b0;
                        d.done  = 1'b1;
                        d.rdata = q.pwe ? '0 : merged;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
            end
        end else begin
            d.preq = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.ctrl <= CTRL_RESET;
        end else begin
            q <= d;
        end
    end

    assign tmo_flag    = q.tmo;
    assign host_busy   = q.busy;
    assign host_done   = q.done;
    assign host_rdata  = q.rdata;
    assign per_req     = q.preq;
    assign per_we      = q.pwe;
    assign per_is_addr = q.pisaddr;
    assign ctl_lines   = q.ctrl & ~(8'h01 << DIR_BIT);
    assign dir_read    = q.ctrl[DIR_BIT];
    assign dir_chg     = q.dirchg;
endmodule

// File: rtl/epp_cycle_ctrl_sva.sv
module epp_cycle_ctrl_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       host_busy,
    input logic       host_done,
    input logic       per_req,
    input logic       per_we,
    input logic       per_ack,
    input logic       per_err,
    input logic [7:0] per_wdata,
    input logic [7:0] ctl_lines,
    input logic       dir_read,
    input logic       dir_chg,
    input logic       tmo_flag
);
    // R2: write cycles only under the write pattern
    p_wr_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (per_req && per_we) |-> (((ctl_lines & 8'h2F) == 8'h04) && !dir_read));

    // R3: read cycles only under the read pattern
    p_rd_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (per_req && !per_we) |-> (((ctl_lines & 8'h2F) == 8'h04) && dir_read));

    // R6: request held with stable byte and direction until acknowledged
    p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (per_req && !per_ack) |=> (per_req && $stable(per_wdata) && $stable(per_we)));

    // R6: request drops after an acknowledge
    p_req_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (per_req && per_ack) |=> !per_req);

    // R7: timeout flag rises only after a peripheral error
    p_tmo_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_flag) |-> $past(per_req && per_ack && per_err));

    // R9: direction pulse only with a changed direction bit
    p_dirchg_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dir_chg |-> (dir_read != $past(dir_read)));

    // R10: no completion while busy, and requests only while busy
    p_busy_nodone_r10: assert property (@(posedge clk) disable iff (!rst_n)
        host_busy |-> !host_done);

    p_req_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        per_req |-> host_busy);
endmodule

bind epp_cycle_ctrl epp_cycle_ctrl_sva u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_busy (host_busy),
    .host_done (host_done),
    .per_req   (per_req),
    .per_we    (per_we),
    .per_ack   (per_ack),
    .per_err   (per_err),
    .per_wdata (per_wdata),
    .ctl_lines (ctl_lines),
    .dir_read  (dir_read),
    .dir_chg   (dir_chg),
    .tmo_flag  (tmo_flag)
);

// File: tb/epp_cycle_ctrl_test.sv
`timescale 1ns/1ps
module epp_cycle_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [1:0]  host_size = '0;
    logic [31:0] host_wdata = '0;
    logic        host_busy, host_done;
    logic [31:0] host_rdata;
    logic        per_req, per_we, per_is_addr;
    logic [7:0]  per_wdata;
    logic        per_ack = 1'b0;
    logic        per_err = 1'b0;
    logic [7:0]  per_rdata = '0;
    logic [7:0]  ctl_lines;
    logic        dir_read, dir_chg;

    always #5 clk = ~clk;

    epp_cycle_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_size(host_size), .host_wdata(host_wdata),
        .host_busy(host_busy), .host_done(host_done), .host_rdata(host_rdata),
        .per_req(per_req), .per_we(per_we), .per_is_addr(per_is_addr),
        .per_wdata(per_wdata), .per_ack(per_ack), .per_err(per_err),
        .per_rdata(per_rdata), .ctl_lines(ctl_lines), .dir_read(dir_read),
        .dir_chg(dir_chg)
    );

    int checks = 0;
    int errors = 0;

    // peripheral responder: acks one cycle after seeing a request
    int         nreq = 0;
    int         n0 = 0;
    int         err_at = 99;
    logic [7:0] log_b [8];
    logic       log_a [8];
    always @(posedge clk) begin
        if (!rst_n) begin
            per_ack <= 1'b0;
            per_err <= 1'b0;
        end else if (per_req && !per_ack) begin
            per_ack   <= 1'b1;
            per_err   <= ((nreq - n0) == err_at);
            per_rdata <= 8'hC0 | 8'(nreq - n0);
            log_b[(nreq - n0) & 7] <= per_wdata;
            log_a[(nreq - n0) & 7] <= per_is_addr;
            nreq <= nreq + 1;
        end else begin
            per_ack <= 1'b0;
            per_err <= 1'b0;
        end
    end

    // monitors sampled away from the clock edge
    int   rises = 0;
    int   dchg = 0;
    logic req_prev = 1'b0;
    always @(negedge clk) begin
        if (per_req && !req_prev) rises++;
        req_prev = per_req;
        if (dir_chg) dchg++;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [2:0] ofs, input logic [1:0] sz,
                          input logic [31:0] wd, output logic [31:0] rd);
        int g;
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_addr = ofs; host_size = sz; host_wdata = wd;
        @(negedge clk);
        host_req = 1'b0;
        g = 0;
        while (!host_done && g < 200) begin
            @(negedge clk);
            g++;
        end
        if (g >= 200) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual busy expected done");
        end
        rd = host_rdata;
    endtask

    typedef struct packed {
        logic [7:0]  ctrl;
        logic        we;
        logic [2:0]  ofs;
        logic [1:0]  sz;
        logic [31:0] wd;
        logic [3:0]  err;
        logic [31:0] exp_rd;
        logic [3:0]  exp_n;
        logic        exp_tmo;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{8'h04, 1'b1, 3'd4, 2'd0, 32'h0000005A, 4'hF, 32'h00000000, 4'd1, 1'b0},
        '{8'h04, 1'b1, 3'd4, 2'd1, 32'h0000BEEF, 4'hF, 32'h00000000, 4'd2, 1'b0},
        '{8'h04, 1'b1, 3'd4, 2'd2, 32'h11223344, 4'hF, 32'h00000000, 4'd4, 1'b0},
        '{8'h24, 1'b0, 3'd4, 2'd2, 32'h00000000, 4'hF, 32'hC3C2C1C0, 4'd4, 1'b0},
        '{8'h24, 1'b0, 3'd4, 2'd1, 32'h00000000, 4'hF, 32'h0000C1C0, 4'd2, 1'b0},
        '{8'h24, 1'b0, 3'd3, 2'd2, 32'h00000000, 4'hF, 32'h000000C0, 4'd1, 1'b0},
        '{8'h84, 1'b1, 3'd3, 2'd2, 32'hDDCCBBA7, 4'hF, 32'h00000000, 4'd1, 1'b0},
        '{8'h24, 1'b1, 3'd4, 2'd0, 32'h0000005A, 4'hF, 32'h00000000, 4'd0, 1'b0},
        '{8'h04, 1'b0, 3'd4, 2'd1, 32'h00000000, 4'hF, 32'h0000FFFF, 4'd0, 1'b0},
        '{8'h0C, 1'b1, 3'd3, 2'd0, 32'h00000012, 4'hF, 32'h00000000, 4'd0, 1'b0},
        '{8'h25, 1'b0, 3'd4, 2'd0, 32'h00000000, 4'hF, 32'h000000FF, 4'd0, 1'b0},
        '{8'h24, 1'b0, 3'd4, 2'd2, 32'h00000000, 4'h1, 32'hFFFFFFC0, 4'd2, 1'b1},
        '{8'h04, 1'b1, 3'd4, 2'd2, 32'h01020304, 4'h0, 32'h00000000, 4'd1, 1'b1},
        '{8'h34, 1'b0, 3'd4, 2'd0, 32'h00000000, 4'hF, 32'h000000C0, 4'd1, 1'b0},
        '{8'h24, 1'b0, 3'd4, 2'd3, 32'h00000000, 4'hF, 32'hC3C2C1C0, 4'd4, 1'b0}
    };
    localparam string TAG [NV] = '{
        "R2 R5", "R2 R5", "R2 R5", "R3 R5", "R3 R5", "R5 addr", "R3 mask",
        "R4 wr", "R4 rd", "R2 R4", "R4 byte", "R7 rd", "R7 wr", "R3 mask", "R5 size3"
    };

    logic [31:0] rd;
    int          r0;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk("R1 reset busy", 32'(host_busy), 32'd0);
        chk("R9 reset lines", 32'(ctl_lines), 32'h0C);
        chk("R9 reset dir", 32'(dir_read), 32'd0);
        access(1'b0, 3'd2, 2'd0, '0, rd);
        chk("R1 reset ctrl", rd, 32'h0C);
        access(1'b0, 3'd1, 2'd0, '0, rd);
        chk("R1 reset status", rd, 32'h0);
        access(1'b0, 3'd0, 2'd0, '0, rd);
        chk("R1 other offset", rd, 32'h0);

        // vector table
        for (int v = 0; v < NV; v++) begin
            access(1'b1, 3'd2, 2'd0, 32'(VEC[v].ctrl), rd);
            access(1'b1, 3'd1, 2'd0, 32'h1, rd);
            err_at = (VEC[v].err == 4'hF) ? 99 : int'(VEC[v].err);
            n0 = nreq;
            r0 = rises;
            access(VEC[v].we, VEC[v].ofs, VEC[v].sz, VEC[v].wd, rd);
            chk({TAG[v], " rdata"}, rd, VEC[v].exp_rd);
            chk({TAG[v], " requests"}, 32'(nreq - n0), 32'(VEC[v].exp_n));
            chk("R6 one rise per byte", 32'(rises - r0), 32'(VEC[v].exp_n));
            if (VEC[v].exp_n != 0) begin
                chk("R5 cycle kind", 32'(log_a[0]), 32'(VEC[v].ofs == 3'd3));
            end
            if (VEC[v].we) begin
                for (int b = 0; b < int'(VEC[v].exp_n); b++) begin
                    chk("R5 byte order", 32'(log_b[b]), 32'(VEC[v].wd[8*b +: 8]));
                end
            end
            err_at = 99;
            access(1'b0, 3'd1, 2'd0, '0, rd);
            chk({TAG[v], " timeout"}, rd, 32'(VEC[v].exp_tmo));
        end

        // R8: sticky flag, clear only with bit 0
        access(1'b1, 3'd2, 2'd0, 32'h04, rd);
        err_at = 0; n0 = nreq;
        access(1'b1, 3'd4, 2'd0, 32'h55, rd);
        err_at = 99;
        access(1'b1, 3'd1, 2'd0, 32'hFE, rd);
        access(1'b0, 3'd1, 2'd0, '0, rd);
        chk("R8 write bit0 clear keeps flag", rd, 32'h1);
        n0 = nreq;
        access(1'b1, 3'd4, 2'd1, 32'h7766, rd);
        access(1'b0, 3'd1, 2'd0, '0, rd);
        chk("R8 sticky after success", rd, 32'h1);
        access(1'b1, 3'd1, 2'd0, 32'h01, rd);
        access(1'b0, 3'd1, 2'd0, '0, rd);
        chk("R8 cleared", rd, 32'h0);

        // R9: direction pulse and stripped control lines
        r0 = dchg;
        access(1'b1, 3'd2, 2'd0, 32'h24, rd);
        @(negedge clk);
        chk("R9 pulse on change", 32'(dchg - r0), 32'd1);
        chk("R9 lines stripped", 32'(ctl_lines), 32'h04);
        chk("R9 dir level", 32'(dir_read), 32'd1);
        access(1'b1, 3'd2, 2'd0, 32'h25, rd);
        @(negedge clk);
        chk("R9 no pulse same dir", 32'(dchg - r0), 32'd1);
        chk("R9 lines follow", 32'(ctl_lines), 32'h05);
        access(1'b1, 3'd2, 2'd0, 32'hC5, rd);
        @(negedge clk);
        chk("R9 pulse back", 32'(dchg - r0), 32'd2);
        chk("R9 high bits pass", 32'(ctl_lines), 32'hC5);

        // R10: request during busy ignored
        access(1'b1, 3'd2, 2'd0, 32'h04, rd);
        n0 = nreq;
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b1; host_addr = 3'd4; host_size = 2'd2; host_wdata = 32'hA1B2C3D4;
        @(negedge clk);
        host_req = 1'b0;
        chk("R10 busy", 32'(host_busy), 32'd1);
        host_req = 1'b1; host_addr = 3'd2; host_wdata = 32'hFF;
        @(negedge clk);
        host_req = 1'b0;
        chk("R10 no done while busy", 32'(host_done), 32'd0);
        begin
            int g = 0;
            while (!host_done && g < 200) begin @(negedge clk); g++; end
        end
        chk("R10 all bytes sent", 32'(nreq - n0), 32'd4);
        access(1'b0, 3'd2, 2'd0, '0, rd);
        chk("R10 ctrl untouched", rd, 32'h04);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1_500_000ns;
        errors++;
        checks++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule